// File: doc/BRIEF.md
# Drive and Motor Control Register

This block is an 8-bit read/write control register for a disk controller. Its fields drive four motor-enable outputs and four drive-select outputs. It also produces an enable for the DMA and interrupt pins, and a software-reset level for the rest of the controller. The host loads the register through a single write strobe with a data byte. The current contents are always visible on a read-back bus.

A 2-bit drive number in the low bits is decoded so that exactly one drive-select output is active. An external polarity input sets the electrical active level of all eight motor and select pins. An operating-mode input decides whether the DMA-enable bit gates the DMA and interrupt pins, or whether those pins stay enabled in every case.

The reset-control bit is active low. While it reads 0, the controller is held in software reset. When a 1 is written back, the software-reset output is held asserted for a parameterised number of extra cycles. This lets two back-to-back writes (0, then 1) meet a minimum reset pulse width at any clock rate. The software reset never clears the register itself.

Top module: `drive_ctl_reg`

## Requirements
- R1: While `rst_n` is low, and after it is released, `rd_data` reads 0x00 until the first write, and `soft_rst` is 1.
- R2: A write with `wr_en` high loads `wr_data` into the register at that clock edge, and `rd_data` shows all 8 bits from then on. With `wr_en` low, the contents do not change.
- R3: Bits 7, 6, 5 and 4 are the motor-enable controls for motors 3, 2, 1 and 0. `motor_pin[i]` is at its active level exactly when bit 4+i is 1.
- R4: Bits 1:0 hold a binary drive number n. `dsel_pin[n]` is at its active level and the other three select pins are inactive.
- R5: When `invert` is 0, the active level of `motor_pin` and `dsel_pin` is 1. When `invert` is 1, the active level is 0. A change of `invert` takes effect without a clock edge.
- R6: When `toggle_mode` is 0, bit 3 is the DMA enable. When bit 3 is 1, `drq_int_oe` and `dak_tc_en` are 1. When bit 3 is 0, both are 0.
- R7: When `toggle_mode` is 1, `drq_int_oe` and `dak_tc_en` are 1 whatever bit 3 holds, and this also applies while `rst_n` is low.
- R8: Bit 2 is the active-low reset-control bit. `soft_rst` is 1 in every cycle in which bit 2 reads 0.
- R9: After the edge that loads a 1 into bit 2 while it read 0, `soft_rst` stays 1 for HOLD_CYCLES-1 further cycles and then falls. A write of 0 followed at once by a write of 1 therefore gives a HOLD_CYCLES-cycle pulse.
- R10: Writing 0x1C, 0x2D, 0x4E or 0x8F selects drive 0, 1, 2 or 3, turns on only that drive's motor, enables DMA, and releases the software reset after the stretch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Current register contents |
| invert | input | 1 | 1 makes the motor and select pins active low |
| toggle_mode | input | 1 | 1 keeps the DMA and interrupt pins always enabled |
| motor_pin | output | 4 | Motor-enable pins, level set by `invert` |
| dsel_pin | output | 4 | Drive-select pins, level set by `invert` |
| drq_int_oe | output | 1 | Output enable for the DMA request and interrupt pins |
| dak_tc_en | output | 1 | Accept DMA acknowledge and terminal count inputs |
| soft_rst | output | 1 | Software reset to the controller, active high |

## Verification
The register contents and the software-reset level change on the clock edge that takes the write. The pin, polarity and DMA-enable outputs are combinational functions of the contents and the two mode inputs, so they follow in the same cycle. The bench drives inputs at the falling edge and samples 2 ns after the rising edge. It updates its model at that edge, so every comparison happens one edge after the write that caused it. The stretch of `soft_rst` is counted in whole cycles from the releasing write until the output falls, and that count is compared with HOLD_CYCLES-1.

// File: rtl/drive_ctl_reg.sv
module drive_ctl_reg #(
  parameter int HOLD_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       invert,
  input  logic       toggle_mode,
  output logic [3:0] motor_pin,
  output logic [3:0] dsel_pin,
  output logic       drq_int_oe,
  output logic       dak_tc_en,
  output logic       soft_rst
);
  localparam int CNT_W = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYCLES - 1);

  logic [7:0]       ctl_q;
  logic [CNT_W-1:0] hold_q;
  logic             dma_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= 8'h00;
    else if (wr_en) ctl_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hold_q <= '0;
    else if (!ctl_q[2])      hold_q <= RELOAD;
    else if (hold_q != '0)   hold_q <= hold_q - CNT_W'(1);
  end

  assign rd_data    = ctl_q;
  assign motor_pin  = ctl_q[7:4] ^ {4{invert}};
  assign dsel_pin   = (4'b0001 << ctl_q[1:0]) ^ {4{invert}};
  assign dma_en     = toggle_mode | ctl_q[3];
  assign drq_int_oe = dma_en;
  assign dak_tc_en  = dma_en;
  assign soft_rst   = ~ctl_q[2] | (hold_q != '0);
endmodule

// File: rtl/drive_ctl_reg_chk.sv
module drive_ctl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       invert,
  input logic       toggle_mode,
  input logic [3:0] motor_pin,
  input logic [3:0] dsel_pin,
  input logic       drq_int_oe,
  input logic       dak_tc_en,
  input logic       soft_rst
);
  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));

  // R4
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dsel_pin ^ {4{invert}}) == 1);

  // R3
  motor_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (motor_pin ^ {4{invert}}) == rd_data[7:4]);

  // R7
  toggle_en_chk: assert property (@(posedge clk)
    toggle_mode |-> (drq_int_oe && dak_tc_en));

  // R6
  dma_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!toggle_mode && !rd_data[3]) |-> (!drq_int_oe && !dak_tc_en));

  // R8
  sw_rst_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[2] |-> soft_rst);

  // R9
  stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[2]) |-> soft_rst);

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(soft_rst) |-> rd_data[2]);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      hw_rst_chk: assert (rd_data == 8'h00 && soft_rst);
    end
  end
endmodule

bind drive_ctl_reg drive_ctl_reg_chk u_chk (.*);

// File: tb/drive_ctl_reg_bench.sv
module drive_ctl_reg_bench;
  localparam int HOLD = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       invert = 1'b0;
  logic       toggle_mode = 1'b0;
  logic [7:0] rd_data;
  logic [3:0] motor_pin, dsel_pin;
  logic       drq_int_oe, dak_tc_en, soft_rst;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] m_reg = 8'h00;
  int         m_hold = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  drive_ctl_reg #(.HOLD_CYCLES(HOLD)) u_drive_ctl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .invert(invert), .toggle_mode(toggle_mode),
    .motor_pin(motor_pin), .dsel_pin(dsel_pin), .drq_int_oe(drq_int_oe),
    .dak_tc_en(dak_tc_en), .soft_rst(soft_rst)
  );

  function automatic logic [3:0] exp_motor(logic [7:0] r, logic inv);
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = (r[4+i] == 1'b1) ? ~inv : inv;
    return v;
  endfunction

  function automatic logic [3:0] exp_dsel(logic [7:0] r, logic inv);
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = (int'(r[1:0]) == i) ? ~inv : inv;
    return v;
  endfunction

  function automatic logic exp_dma(logic [7:0] r, logic tm);
    return tm ? 1'b1 : r[3];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 readback", rd_data, m_reg);
    chk(invert ? "R5 motor inverted" : "R3 motor", motor_pin, exp_motor(m_reg, invert));
    chk(invert ? "R5 select inverted" : "R4 select", dsel_pin, exp_dsel(m_reg, invert));
    chk(toggle_mode ? "R7 drq_int_oe" : "R6 drq_int_oe", drq_int_oe, exp_dma(m_reg, toggle_mode));
    chk(toggle_mode ? "R7 dak_tc_en" : "R6 dak_tc_en", dak_tc_en, exp_dma(m_reg, toggle_mode));
    chk(m_reg[2] ? "R9 soft_rst" : "R8 soft_rst", soft_rst, (!m_reg[2] || m_hold > 0) ? 1 : 0);
  endtask

  task automatic cycle(logic we, logic [7:0] d);
    @(negedge clk);
    wr_en = we;
    wr_data = d;
    @(posedge clk);
    if (!m_reg[2]) m_hold = HOLD - 1;
    else if (m_hold > 0) m_hold--;
    if (we) m_reg = d;
    #2;
    check_all();
  endtask

  task automatic hw_reset();
    @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b0;
    m_reg = 8'h00;
    m_hold = 0;
    #1;
    chk("R1 reset contents", rd_data, 8'h00);
    chk("R1 reset soft_rst", soft_rst, 1);
    chk("R1 reset motors", motor_pin, exp_motor(8'h00, invert));
    toggle_mode = 1'b1;
    @(posedge clk); #2;
    chk("R7 enable in reset", {drq_int_oe, dak_tc_en}, 2'b11);
    toggle_mode = 1'b0;
    #1;
    chk("R6 disabled in reset", {drq_int_oe, dak_tc_en}, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    cycle(1'b0, 8'h00);
    chk("R1 after release", {rd_data, soft_rst}, {8'h00, 1'b1});
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    #1;
    hw_reset();

    // R9: back-to-back 0 then 1
    cycle(1'b1, 8'h08);
    cycle(1'b1, 8'h0C);
    n = 0;
    while (soft_rst && n < 20) begin
      cycle(1'b0, 8'h00);
      n++;
    end
    chk("R9 stretch length", n, HOLD - 1);

    // R10 presets, both polarities
    for (int p = 0; p < 2; p++) begin
      invert = p[0];
      for (int d = 0; d < 4; d++) begin
        logic [7:0] v;
        v = (8'h10 << d) | 8'h0C | 8'(d);
        cycle(1'b1, v);
        for (int k = 0; k < HOLD; k++) cycle(1'b0, 8'h00);
        chk("R10 select", dsel_pin ^ {4{invert}}, 4'b0001 << d);
        chk("R10 motor", motor_pin ^ {4{invert}}, 4'b0001 << d);
        chk("R10 dma and release", {drq_int_oe, soft_rst}, 2'b10);
      end
    end

    // R5: polarity flip without a clock edge
    invert = 1'b0;
    cycle(1'b1, 8'hA6);
    #1 invert = 1'b1;
    #1;
    chk("R5 live invert motor", motor_pin, 4'b0101);
    chk("R5 live invert select", dsel_pin, 4'b1011);

    // R2: contents hold with no strobe
    cycle(1'b0, 8'h55);
    chk("R2 ignored data", rd_data, 8'hA6);

    // mid-run hardware reset with nonzero contents
    cycle(1'b1, 8'hFF);
    hw_reset();

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic we;
      logic [7:0] d;
      we = ($urandom_range(0, 3) != 0);
      d  = 8'($urandom);
      if ($urandom_range(0, 7) == 0) d[2] = 1'b0;
      if ($urandom_range(0, 15) == 0) invert = ~invert;
      if ($urandom_range(0, 15) == 0) toggle_mode = ~toggle_mode;
      cycle(we, d);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule